// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the slave-side protocol engine of a byte-wide serial EEPROM. A host drives chip select, serial clock and serial data in the usual SPI mode-0/mode-3 manner. The engine takes in a one-byte opcode, then, where the command needs them, a 16-bit address and data bytes. It answers status and memory reads on serial data out, and it hands completed writes to an internal programming timer that stands in for the cell program time.

All serial pins are sampled in the system clock domain through short synchronisers and edge detectors, so one clock runs the whole block. Page writes gather bytes in a page latch that records which bytes were loaded, and only those bytes reach the array when the timer expires. A separate protection unit sees the target page and the nonvolatile protection bits, and answers with two permit inputs. When the relevant permit is low, the write is not started.

A command takes effect only if chip select rises after a legal number of clocks for that opcode. Any other count leaves the device unchanged.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Opcodes (MSB first) are 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status, 0x01 write status, 0x03 read, 0x02 write. Any other first byte makes the device ignore all further clocks and keep data out disabled until chip select goes high.
- R2: Serial data in is taken on rising clock edges and serial data out changes only after falling edges. The output enable `spi_miso_oe` is low after reset, while deselected, and in every phase that is not returning data.
- R3: Set-write-enable and clear-write-enable act only when chip select rises after exactly 8 clocks. With 7, 9 or any other count the write-enable bit keeps its value.
- R4: The status byte reads {srwd, 0, 0, 0, bp1, bp0, wel, wip} from bit 7 down to bit 0. Write-status updates only bits 7, 3 and 2 and requires exactly 16 clocks, a set write-enable bit and `sts_permit` high. The new value appears when programming ends. `prot_cfg` = {srwd, bp1, bp0}. Read status repeats the byte while clocks continue.
- R5: Write starts programming only when chip select rises after exactly 24 + 8m clocks with m ≥ 1 and write-enable is set. Any other count cancels the command with array and write-enable unchanged.
- R6: Read returns the byte at the address taken from the low ADDR_W bits of the 16-bit address; the upper bits are ignored. While clocks continue, the address increments after each byte and wraps from the last address to 0.
- R7: Within a write, only the in-page offset increments, wrapping inside the page, so later bytes overwrite earlier ones. At commit only offsets that were loaded change.
- R8: A read or write opcode received while programming is in progress is ignored: no data is output and nothing is stored.
- R9: Programming lasts PROG_CYCLES clocks with wip = 1. At its end wip and wel both return to 0.
- R10: A legal write or write-status with its permit input low does not start programming and leaves write-enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| arr_permit | input | 1 | Protection unit allows array write to `wr_page` |
| sts_permit | input | 1 | Protection unit allows status write |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Data out drive enable (low = high impedance) |
| wr_page | output | ADDR_W-log2(PAGE_BYTES) | Page addressed by the current write |
| prot_cfg | output | 3 | Nonvolatile bits {srwd, bp1, bp0} |

## Verification
The bench builds the engine with ADDR_W = 7 and PAGE_BYTES = 8, giving 128 bytes in 16 pages, and with PROG_CYCLES = 400. This lets every page be written and the whole array read back in one sequential burst that crosses the wrap from 127 to 0. The programming window is long enough that a status poll or a second opcode can land while programming is still running. Clock counts one short of and one beyond each legal length are driven for every command family.

// File: rtl/eeprom_pkg.sv
`timescale 1ns/1ps
package eeprom_pkg;

    typedef enum logic [7:0] {
        OP_WREN  = 8'h06,
        OP_WRDI  = 8'h04,
        OP_RDSR  = 8'h05,
        OP_WRSR  = 8'h01,
        OP_READ  = 8'h03,
        OP_WRITE = 8'h02
    } opcode_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OP, PH_AHI, PH_ALO, PH_DATA, PH_DEAD
    } phase_e;

    typedef struct packed {
        logic       srwd;
        logic [1:0] bp;
    } nv_cfg_t;

    function automatic logic known_op(input logic [7:0] b);
        return (b == OP_WREN) || (b == OP_WRDI) || (b == OP_RDSR) ||
               (b == OP_WRSR) || (b == OP_READ) || (b == OP_WRITE);
    endfunction

    function automatic logic [7:0] pack_status(input nv_cfg_t c, input logic wel, input logic wip);
        return {c.srwd, 3'b000, c.bp, wel, wip};
    endfunction

endpackage

// File: rtl/ee_sync.sv
`timescale 1ns/1ps
module ee_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic csn_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic sel,
    output logic mosi_s
);
    localparam int QW = SYNC_STAGES + 1;
    localparam logic [1:0] RST_VAL = 2'b10;   // index 1 = chip select idles high

    logic [1:0] raw;
    assign raw = {csn_in, sck_in};

    for (genvar g = 0; g < 2; g++) begin : g_chain
        logic [QW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= {QW{RST_VAL[g]}};
            else     q <= {q[QW-2:0], raw[g]};
        end
    end

    logic [SYNC_STAGES-1:0] mq;
    always_ff @(posedge clk) begin
        if (rst) mq <= '0;
        else     mq <= {mq[SYNC_STAGES-2:0], mosi_in};
    end

    assign sck_rise = g_chain[0].q[QW-2] & ~g_chain[0].q[QW-1];
    assign sck_fall = ~g_chain[0].q[QW-2] & g_chain[0].q[QW-1];
    assign cs_fall  = ~g_chain[1].q[QW-2] & g_chain[1].q[QW-1];
    assign cs_rise  = g_chain[1].q[QW-2] & ~g_chain[1].q[QW-1];
    assign sel      = ~g_chain[1].q[QW-2];
    assign mosi_s   = mq[SYNC_STAGES-1];
endmodule

// File: rtl/ee_page_latch.sv
`timescale 1ns/1ps
module ee_page_latch #(
    parameter int PAGE_BYTES = 32,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    we,
    input  logic [PW-1:0]           idx,
    input  logic [7:0]              wdata,
    output logic [PAGE_BYTES*8-1:0] data,
    output logic [PAGE_BYTES-1:0]   valid
);
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        logic [7:0] b;
        logic       v;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                b <= '0;
                v <= 1'b0;
            end else if (we && idx == PW'(i)) begin
                b <= wdata;
                v <= 1'b1;
            end
        end
        assign data[i*8 +: 8] = b;
        assign valid[i]       = v;
    end

    // R7: a cleared latch starts the next write with no loaded bytes
    p_clr_empties_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (valid == '0));
endmodule

// File: rtl/ee_array.sv
`timescale 1ns/1ps
module ee_array
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 4000,
    localparam int PW    = $clog2(PAGE_BYTES),
    localparam int NPW   = ADDR_W - PW,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int CW    = $clog2(PROG_CYCLES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_arr,
    input  logic                    start_sts,
    input  logic [NPW-1:0]          page,
    input  logic [PAGE_BYTES*8-1:0] lat_data,
    input  logic [PAGE_BYTES-1:0]   lat_valid,
    input  nv_cfg_t                 sts_in,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rdata,
    output logic                    busy,
    output logic                    done,
    output nv_cfg_t                 nv
);
    logic [7:0]     mem [DEPTH];
    logic [CW-1:0]  cnt;
    logic           kind_sts;
    logic [NPW-1:0] pg_q;
    nv_cfg_t        sts_hold;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            kind_sts <= 1'b0;
            pg_q     <= '0;
            sts_hold <= '0;
            nv       <= '0;
        end else if (start_arr || start_sts) begin
            busy     <= 1'b1;
            cnt      <= CW'(PROG_CYCLES - 1);
            kind_sts <= start_sts;
            pg_q     <= page;
            sts_hold <= sts_in;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
                if (kind_sts) nv <= sts_hold;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (done && !kind_sts) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (lat_valid[i]) mem[{pg_q, PW'(i)}] <= lat_data[i*8 +: 8];
            end
        end
        rdata <= mem[rd_addr];
    end

    // R9: once started, programming runs until its count expires
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> busy);
endmodule

// File: rtl/spi_eeprom_ctrl.sv
`timescale 1ns/1ps
module spi_eeprom_ctrl
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 4000,
    parameter int SYNC_STAGES = 2,
    localparam int PW  = $clog2(PAGE_BYTES),
    localparam int NPW = ADDR_W - PW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           spi_sck,
    input  logic           spi_csn,
    input  logic           spi_mosi,
    input  logic           arr_permit,
    input  logic           sts_permit,
    output logic           spi_miso,
    output logic           spi_miso_oe,
    output logic [NPW-1:0] wr_page,
    output logic [2:0]     prot_cfg
);
    logic sck_rise, sck_fall, cs_fall, cs_rise, sel, mosi_s;

    ee_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck_in(spi_sck), .csn_in(spi_csn), .mosi_in(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sel(sel), .mosi_s(mosi_s)
    );

    phase_e            ph;
    logic [7:0]        op_q;
    logic [6:0]        shreg;
    logic [2:0]        bitcnt;
    logic [1:0]        dcnt;
    logic [ADDR_W-1:0] addr_sh;
    logic [ADDR_W-1:0] rd_ptr;
    logic [NPW-1:0]    pg_q;
    logic [PW-1:0]     off_q;
    nv_cfg_t           sr_new;
    logic              wel;
    logic              out_en;
    logic [7:0]        oreg;
    logic [2:0]        obit;

    logic                    busy, done;
    logic [7:0]              rdata;
    nv_cfg_t                 nv;
    logic [PAGE_BYTES*8-1:0] lat_data;
    logic [PAGE_BYTES-1:0]   lat_valid;

    logic [7:0]        in_byte;
    logic [ADDR_W-1:0] addr_next;
    logic              active_rise, byte_done, at_bound;
    logic              lat_we, lat_clr, start_arr, start_sts, exact8;

    assign in_byte     = {shreg, mosi_s};
    assign addr_next   = {addr_sh[ADDR_W-2:0], mosi_s};
    assign active_rise = sck_rise && sel && (ph != PH_IDLE) && (ph != PH_DEAD);
    assign byte_done   = active_rise && (bitcnt == 3'd7);
    assign at_bound    = (ph == PH_DATA) && (bitcnt == 3'd0);
    assign exact8      = cs_rise && at_bound && (dcnt == 2'd0);
    assign lat_clr     = byte_done && (ph == PH_OP) && (in_byte == OP_WRITE) && !busy;
    assign lat_we      = byte_done && (ph == PH_DATA) && (op_q == OP_WRITE);
    assign start_sts   = cs_rise && at_bound && (op_q == OP_WRSR) && (dcnt == 2'd1)
                         && wel && sts_permit && !busy;
    assign start_arr   = cs_rise && at_bound && (op_q == OP_WRITE) && (dcnt != 2'd0)
                         && wel && arr_permit && !busy;

    ee_page_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
        .clk(clk), .rst(rst), .clr(lat_clr), .we(lat_we), .idx(off_q), .wdata(in_byte),
        .data(lat_data), .valid(lat_valid)
    );

    ee_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_array (
        .clk(clk), .rst(rst), .start_arr(start_arr), .start_sts(start_sts), .page(pg_q),
        .lat_data(lat_data), .lat_valid(lat_valid), .sts_in(sr_new), .rd_addr(rd_ptr),
        .rdata(rdata), .busy(busy), .done(done), .nv(nv)
    );

    // Command sequencing and serial shifting
    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE;  op_q <= '0;   shreg <= '0;  bitcnt <= '0; dcnt <= '0;
            addr_sh <= '0;  rd_ptr <= '0; pg_q <= '0;   off_q <= '0;  sr_new <= '0;
            out_en <= 1'b0; oreg <= '0;   obit <= '0;
        end else begin
            if (cs_fall) begin
                ph <= PH_OP; bitcnt <= '0; dcnt <= '0; out_en <= 1'b0; obit <= '0;
            end else if (cs_rise) begin
                ph <= PH_IDLE; out_en <= 1'b0;
            end else if (active_rise) begin
                shreg  <= in_byte[6:0];
                bitcnt <= bitcnt + 3'd1;
                if (ph == PH_AHI || ph == PH_ALO) addr_sh <= addr_next;
                if (bitcnt == 3'd7) begin
                    case (ph)
                        PH_OP: begin
                            op_q <= in_byte;
                            if (!known_op(in_byte) ||
                                (busy && (in_byte == OP_READ || in_byte == OP_WRITE)))
                                ph <= PH_DEAD;
                            else if (in_byte == OP_READ || in_byte == OP_WRITE)
                                ph <= PH_AHI;
                            else begin
                                ph     <= PH_DATA;
                                out_en <= (in_byte == OP_RDSR);
                            end
                        end
                        PH_AHI: ph <= PH_ALO;
                        PH_ALO: begin
                            rd_ptr <= addr_next;
                            pg_q   <= addr_next[ADDR_W-1:PW];
                            off_q  <= addr_next[PW-1:0];
                            ph     <= PH_DATA;
                            out_en <= (op_q == OP_READ);
                        end
                        PH_DATA: begin
                            if (dcnt != 2'd3) dcnt <= dcnt + 2'd1;
                            if (op_q == OP_WRSR)  sr_new <= '{srwd: in_byte[7], bp: in_byte[3:2]};
                            if (op_q == OP_WRITE) off_q  <= off_q + PW'(1);
                        end
                        default: ph <= ph;
                    endcase
                end
            end

            if (sck_fall && sel && out_en) begin
                if (obit == 3'd0) begin
                    if (op_q == OP_READ) begin
                        oreg   <= rdata;
                        rd_ptr <= rd_ptr + ADDR_W'(1);
                    end else begin
                        oreg <= pack_status(nv, wel, busy);
                    end
                end else begin
                    oreg <= {oreg[6:0], 1'b0};
                end
                obit <= obit + 3'd1;
            end
        end
    end

    // Write-enable latch: completion of programming has priority
    always_ff @(posedge clk) begin
        if (rst)                                wel <= 1'b0;
        else if (done)                          wel <= 1'b0;
        else if (exact8 && op_q == OP_WREN)     wel <= 1'b1;
        else if (exact8 && op_q == OP_WRDI)     wel <= 1'b0;
    end

    assign spi_miso    = oreg[7];
    assign spi_miso_oe = sel && out_en;
    assign wr_page     = pg_q;
    assign prot_cfg    = {nv.srwd, nv.bp};

    // R1: a rejected opcode never drives data out
    p_dead_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DEAD) |-> !spi_miso_oe);
    // R2: data out moves only after a falling serial clock edge
    p_so_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !sck_fall |=> $stable(spi_miso));
    // R5: programming only begins with the write-enable latch set
    p_start_had_wel_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel));
    // R8: page latch is never loaded while programming runs
    p_latch_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        lat_we |-> !busy);
    // R9: write-enable is clear when programming ends
    p_wel_drop_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);
endmodule

// File: tb/spi_eeprom_ctrl_test.sv
`timescale 1ns/1ps
module spi_eeprom_ctrl_test;
    localparam int AW = 7;
    localparam int PB = 8;
    localparam int PC = 400;
    localparam int H  = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic arr_permit = 1'b1, sts_permit = 1'b1;
    logic miso, miso_oe;
    logic [AW-$clog2(PB)-1:0] wr_page;
    logic [2:0] prot_cfg;

    spi_eeprom_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) uut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .arr_permit(arr_permit), .sts_permit(sts_permit), .spi_miso(miso),
        .spi_miso_oe(miso_oe), .wr_page(wr_page), .prot_cfg(prot_cfg)
    );

    always #2.5 clk = ~clk;

    int   n_checks = 0, n_fail = 0, cyc = 0;
    logic finished = 1'b0;
    logic oe_hit = 1'b0;
    logic [7:0] em [DEPTH];
    logic [7:0] wbuf [16];
    logic [7:0] junk, st;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000 && !finished) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: got cycle %0d expected finish before it", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic o);
        mosi = b;
        tick(H);
        o = miso;
        if (miso_oe) oe_hit = 1'b1;
        sck = 1'b1;
        tick(H);
        sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) sbit(b[i], r[i]);
    endtask

    task automatic sbits(input logic [7:0] b, input int n);
        logic d;
        for (int i = 7; i > 7 - n; i--) sbit(b[i], d);
    endtask

    task automatic cs_on;
        csn = 1'b0;
        oe_hit = 1'b0;
        tick(H);
    endtask

    task automatic cs_off;
        tick(H);
        csn = 1'b1;
        tick(3 * H);
    endtask

    task automatic simple(input logic [7:0] op);
        cs_on; sbyte(op, junk); cs_off;
    endtask

    task automatic rdsr(output logic [7:0] s);
        cs_on; sbyte(8'h05, junk); sbyte(8'h00, s); cs_off;
    endtask

    task automatic wrsr(input logic [7:0] v);
        cs_on; sbyte(8'h01, junk); sbyte(v, junk); cs_off;
    endtask

    task automatic write_n(input logic [15:0] a, input int n);
        cs_on;
        sbyte(8'h02, junk); sbyte(a[15:8], junk); sbyte(a[7:0], junk);
        for (int k = 0; k < n; k++) sbyte(wbuf[k], junk);
        cs_off;
    endtask

    task automatic model_write(input logic [15:0] a, input int n);
        int base, off;
        base = int'(a[AW-1:0]) & ~(PB - 1);
        off  = int'(a[AW-1:0]) & (PB - 1);
        for (int k = 0; k < n; k++) em[base + ((off + k) % PB)] = wbuf[k];
    endtask

    task automatic read_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] r;
        cs_on;
        sbyte(8'h03, junk); sbyte(a[15:8], junk); sbyte(a[7:0], junk);
        for (int k = 0; k < n; k++) begin
            int ea;
            sbyte(8'h00, r);
            ea = (int'(a[AW-1:0]) + k) % DEPTH;
            check(r == em[ea], req, r, em[ea]);
        end
        cs_off;
    endtask

    task automatic wait_prog;
        tick(PC + 40);
    endtask

    task automatic status_is(input logic [7:0] e, input string req);
        rdsr(st);
        check(st == e, req, st, e);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);

        // R2 / R4: reset state
        check(miso_oe == 1'b0, "R2 oe after reset", miso_oe, 0);
        check(prot_cfg == 3'b000, "R4 prot_cfg after reset", prot_cfg, 0);
        status_is(8'h00, "R4 status after reset");

        // R3: exact eight-clock enable/disable
        cs_on; sbyte(8'h06, junk); sbits(8'h00, 1); cs_off;
        status_is(8'h00, "R3 enable with 9 clocks ignored");
        simple(8'h06);
        status_is(8'h02, "R3 enable with 8 clocks");
        cs_on; sbits(8'h04, 7); cs_off;
        status_is(8'h02, "R3 disable with 7 clocks ignored");

        // R1: unknown opcode deafens the device for the rest of the select
        cs_on; sbyte(8'hA5, junk); sbyte(8'h04, junk); sbyte(8'h05, junk); cs_off;
        check(oe_hit == 1'b0, "R1 no output after unknown opcode", oe_hit, 0);
        status_is(8'h02, "R1 following clear-enable not acted on");
        simple(8'h04);
        status_is(8'h00, "R3 disable with 8 clocks");

        // R9 / R6: fill every page, watching the first programming window
        for (int p = 0; p < DEPTH / PB; p++) begin
            for (int k = 0; k < PB; k++) wbuf[k] = 8'((p * PB + k) * 37 + 11);
            simple(8'h06);
            write_n(16'(p * PB), PB);
            model_write(16'(p * PB), PB);
            if (p == 0) begin
                status_is(8'h03, "R9 wip and wel while programming");
            end
            wait_prog;
            if (p == 0) status_is(8'h00, "R9 wip and wel clear after programming");
        end

        // R6: sequential read with ignored upper bits and array wrap
        read_chk(16'hFFFD, DEPTH + 3, "R6 sequential read with wrap");
        check(miso_oe == 1'b0, "R2 oe low after deselect", miso_oe, 0);

        // R7: page wrap, later bytes overwrite earlier
        for (int k = 0; k < 10; k++) wbuf[k] = 8'(200 + k);
        simple(8'h06);
        write_n(16'h0015, 10);
        model_write(16'h0015, 10);
        wait_prog;
        read_chk(16'h0010, PB, "R7 page wrap overwrite");

        // R7: only loaded bytes committed
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        simple(8'h06);
        write_n(16'h0023, 2);
        model_write(16'h0023, 2);
        wait_prog;
        read_chk(16'h0020, PB, "R7 partial page commit");

        // R5: illegal clock counts cancel a write
        for (int k = 0; k < 3; k++) wbuf[k] = 8'hEE;
        simple(8'h06);
        cs_on;
        sbyte(8'h02, junk); sbyte(8'h00, junk); sbyte(8'h40, junk);
        for (int k = 0; k < 3; k++) sbyte(wbuf[k], junk);
        sbits(8'hFF, 3);
        cs_off;
        status_is(8'h02, "R5 write with extra bits not started");
        write_n(16'h0040, 0);
        status_is(8'h02, "R5 write with no data byte not started");
        read_chk(16'h0040, 4, "R5 cancelled write left array unchanged");

        // R10: permits gate both kinds of write
        arr_permit = 1'b0;
        wbuf[0] = 8'h11;
        write_n(16'h0048, 1);
        status_is(8'h02, "R10 array write blocked by permit");
        arr_permit = 1'b1;
        read_chk(16'h0048, 1, "R10 array unchanged when blocked");
        sts_permit = 1'b0;
        wrsr(8'h8C);
        status_is(8'h02, "R10 status write blocked by permit");
        check(prot_cfg == 3'b000, "R10 prot_cfg unchanged", prot_cfg, 0);
        sts_permit = 1'b1;

        // R4: status write touches only bits 7, 3, 2
        wrsr(8'hFF);
        wait_prog;
        status_is(8'h8C, "R4 status write result");
        check(prot_cfg == 3'b111, "R4 prot_cfg after status write", prot_cfg, 7);
        simple(8'h06);
        cs_on; sbyte(8'h01, junk); sbyte(8'h00, junk); sbits(8'h00, 1); cs_off;
        status_is(8'h8E, "R4 status write with 17 clocks ignored");
        cs_on; sbyte(8'h05, junk); sbyte(8'h00, st); sbyte(8'h00, junk); cs_off;
        check(st == 8'h8E, "R4 repeated status read", st, 8'h8E);
        wrsr(8'h00);
        wait_prog;
        status_is(8'h00, "R4 status restored");

        // R8: write during programming ignored
        wbuf[0] = 8'h77;
        simple(8'h06);
        write_n(16'h0030, 1);
        model_write(16'h0030, 1);
        wbuf[0] = 8'h99;
        write_n(16'h0038, 1);
        wait_prog;
        read_chk(16'h0030, 16, "R8 write during programming dropped");

        // R8: read during programming gives no output
        wbuf[0] = 8'h42;
        simple(8'h06);
        write_n(16'h0041, 1);
        model_write(16'h0041, 1);
        cs_on;
        sbyte(8'h03, junk); sbyte(8'h00, junk); sbyte(8'h00, junk); sbyte(8'h00, junk);
        cs_off;
        check(oe_hit == 1'b0, "R8 read during programming silent", oe_hit, 0);
        wait_prog;
        read_chk(16'h0040, PB, "R8 array after programming");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule